// File: doc/BRIEF.md
# GPIO Controller with Reset-Time Clock Mask Load

This block controls four general-purpose pins. Software changes the output levels and the output enables through one 32-bit write. Each quantity has its own set field and its own clear field, so a single pin can change without a read-modify-write. A read of the same word returns the present output levels, the present enables and the live pin inputs.

When reset is released, the block first takes the pins to load a 16-bit clock-disable mask serially. Pin 0 becomes a shift clock and pin 1 is held high as the shift-enable line. The serial data comes in on a dedicated input. All this time the block holds its secondary-reset output asserted. Once the sixteenth bit is captured, the block drops secondary reset and turns off the pin drivers, and from then on the pins follow the registers. The mask drives the clock-disable logic directly, and a later register write can replace it.

Top module: `gpio_mask_ctl`

## Requirements
- R1: While reset is held, and in the first cycle after its release, `sec_reset` is 1, `gpio_oe` is 0011b, `gpio_out[1]` is 1, `gpio_out[0]` is 0 and `clk_disable_mask` is 0.
- R2: During the load, `gpio_out[0]` toggles on every core clock, so one bit takes two clocks. `mask_in` is sampled at the edge that ends a cycle in which `gpio_out[0]` is 1. The first bit sampled ends up in mask bit 15 and the last in bit 0.
- R3: `sec_reset` stays 1 for exactly 32 clock edges after reset release and then stays 0. After that edge `gpio_oe` is 0000b and `gpio_out` is 0000b.
- R4: After the load, changes on `mask_in` have no effect on `clk_disable_mask`.
- R5: In a write (`wr_en`=1), `wr_data[15:12]` sets and `wr_data[11:8]` clears output data bits. The result appears on `gpio_out` one clock later, and reads show it in both `rd_data[15:12]` and `rd_data[11:8]`.
- R6: In a write, `wr_data[23:20]` sets and `wr_data[19:16]` clears output enable bits. The result appears on `gpio_oe` one clock later, and reads show it in both `rd_data[23:20]` and `rd_data[19:16]`.
- R7: A pin whose set bit and clear bit are both 1 in the same write keeps its value. A 0 in any set or clear bit has no effect.
- R8: `rd_data[31:28]` equals `gpio_in`. `rd_data[27:24]` and `rd_data[7:0]` are 0.
- R9: Writes to the registers (`wr_en`) and to the mask (`mask_wr`) made while `sec_reset` is 1 are ignored.
- R10: After the load, `mask_wr`=1 replaces `clk_disable_mask` with `mask_wr_data` at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Register write word (set/clear fields) |
| rd_data | output | 32 | Register read word |
| mask_wr | input | 1 | Mask overwrite strobe |
| mask_wr_data | input | 16 | New mask value |
| mask_in | input | 1 | Serial mask data during load |
| gpio_in | input | 4 | Pin input levels |
| gpio_out | output | 4 | Pin output levels |
| gpio_oe | output | 4 | Pin output enables |
| sec_reset | output | 1 | Secondary reset, active high |
| clk_disable_mask | output | 16 | Captured clock-disable mask |

## Verification
A register write or a mask write shows up on the pins, on the read word and on the mask one clock edge after the strobe. The bench drives each strobe at a falling edge and checks at the following falling edge. Pin inputs reach `rd_data` with no clock in between, so the bench checks them in the same half cycle. During the load, the bench watches `gpio_out[0]` at each falling edge. When it sees the line high, it presents the next mask bit, which the next rising edge samples. The bench also counts the falling edges at which `sec_reset` is still high, so the 32-edge length of the load is checked.

// File: rtl/gpio_mask_ctl.sv
module gpio_mask_ctl #(
  parameter int NPIN   = 4,
  parameter int MASK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [31:0]       wr_data,
  output logic [31:0]       rd_data,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_wr_data,
  input  logic              mask_in,
  input  logic [NPIN-1:0]   gpio_in,
  output logic [NPIN-1:0]   gpio_out,
  output logic [NPIN-1:0]   gpio_oe,
  output logic              sec_reset,
  output logic [MASK_W-1:0] clk_disable_mask
);
  localparam int CW = $clog2(MASK_W);

  logic            loading, phase;
  logic [CW-1:0]   bitcnt;
  logic [NPIN-1:0] out_q, oe_q;
  logic [NPIN-1:0] d_clr, d_set, e_clr, e_set;
  logic [MASK_W-1:0] mask_q;

  assign d_clr = wr_data[8+:NPIN];
  assign d_set = wr_data[12+:NPIN];
  assign e_clr = wr_data[16+:NPIN];
  assign e_set = wr_data[20+:NPIN];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loading <= 1'b1;
      phase   <= 1'b0;
      bitcnt  <= '0;
      mask_q  <= '0;
    end else if (loading) begin
      phase <= ~phase;
      if (phase) begin
        mask_q <= {mask_q[MASK_W-2:0], mask_in};
        bitcnt <= bitcnt + 1'b1;
        if (bitcnt == CW'(MASK_W-1)) loading <= 1'b0;
      end
    end else if (mask_wr) begin
      mask_q <= mask_wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      oe_q  <= '0;
    end else if (wr_en && !loading) begin
      out_q <= (out_q & ~(d_clr & ~d_set)) | (d_set & ~d_clr);
      oe_q  <= (oe_q  & ~(e_clr & ~e_set)) | (e_set & ~e_clr);
    end
  end

  assign sec_reset        = loading;
  assign clk_disable_mask = mask_q;
  assign gpio_out = loading ? {{(NPIN-2){1'b0}}, 1'b1, phase} : out_q;
  assign gpio_oe  = loading ? {{(NPIN-2){1'b0}}, 2'b11} : oe_q;
  assign rd_data  = {gpio_in, 4'b0, oe_q, oe_q, out_q, out_q, 8'b0};

  assert_shift_ends_on_clk_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sec_reset) |-> $past(gpio_out[0]));
  assert_reset_stays_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !sec_reset |=> !sec_reset);
  assert_mask_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_reset && !mask_wr) |=> $stable(clk_disable_mask));
  assert_both_bits_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !sec_reset && (wr_data[15:12] == wr_data[11:8])) |=> $stable(out_q));
  assert_write_ignored_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reset |=> $stable(out_q));
  assert_write_ignored_oe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sec_reset |=> $stable(oe_q));
endmodule

// File: tb/gpio_mask_ctl_test.sv
module gpio_mask_ctl_test;
  logic clk = 0, rst_n = 0;
  logic wr_en = 0, mask_wr = 0, mask_in = 0;
  logic [31:0] wr_data = '0;
  logic [15:0] mask_wr_data = '0;
  logic [3:0]  gpio_in = '0;
  logic [31:0] rd_data;
  logic [3:0]  gpio_out, gpio_oe;
  logic        sec_reset;
  logic [15:0] clk_disable_mask;
  int errors = 0, checks = 0, cycles = 0;

  always #5 clk = ~clk;

  gpio_mask_ctl uut (.clk, .rst_n, .wr_en, .wr_data, .rd_data, .mask_wr, .mask_wr_data,
    .mask_in, .gpio_in, .gpio_out, .gpio_oe, .sec_reset, .clk_disable_mask);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  localparam logic [15:0] PAT = 16'hA5C3;
  // {write word, expected out, expected oe}
  localparam logic [39:0] VEC [6] = '{
    {32'h0000_5000, 4'h5, 4'h0},
    {32'h00F0_0000, 4'h5, 4'hF},
    {32'h0000_8100, 4'hC, 4'hF},
    {32'h0003_FF00, 4'hC, 4'hC},
    {32'h0000_0000, 4'hC, 4'hC},
    {32'h0030_3F00, 4'h0, 4'hF}
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int n, idx;
    logic pins_ok;
    repeat (3) @(negedge clk);
    check("R1 sec_reset", sec_reset, 1);
    check("R1 oe", gpio_oe, 4'b0011);
    check("R1 out", gpio_out, 4'b0010);
    check("R1 mask", clk_disable_mask, 0);
    rst_n = 1;
    n = 0; idx = 15; pins_ok = 1;
    while (sec_reset && n < 100) begin
      if (gpio_oe !== 4'b0011 || gpio_out[1] !== 1'b1 || gpio_out[0] !== n[0]) pins_ok = 0;
      if (gpio_out[0]) begin mask_in = PAT[idx]; idx--; end
      if (n == 5) begin wr_en = 1; wr_data = 32'h00FF_F000; mask_wr = 1; mask_wr_data = 16'hFFFF; end
      if (n == 6) begin wr_en = 0; wr_data = 0; mask_wr = 0; end
      n++;
      @(negedge clk);
    end
    check("R2 shift pins", pins_ok, 1);
    check("R3 load length", n, 32);
    check("R2 mask value", clk_disable_mask, PAT);
    check("R3 oe released", gpio_oe, 0);
    check("R9 write ignored", gpio_out, 0);
    check("R9 read ignored", rd_data[23:8], 0);
    repeat (3) begin mask_in = ~mask_in; @(negedge clk); end
    check("R4 mask_in ignored", clk_disable_mask, PAT);
    check("R3 sec_reset low", sec_reset, 0);

    for (int i = 0; i < 6; i++) begin
      wr_en = 1; wr_data = VEC[i][39:8];
      @(negedge clk);
      wr_en = 0; wr_data = 0;
      check($sformatf("R5 R7 out vec%0d", i), gpio_out, VEC[i][7:4]);
      check($sformatf("R6 R7 oe vec%0d", i), gpio_oe, VEC[i][3:0]);
      check($sformatf("R5 R6 read vec%0d", i), rd_data[23:8],
            {VEC[i][3:0], VEC[i][3:0], VEC[i][7:4], VEC[i][7:4]});
    end

    gpio_in = 4'h9; #1;
    check("R8 input read", rd_data[31:28], 4'h9);
    check("R8 reserved", {rd_data[27:24], rd_data[7:0]}, 0);
    gpio_in = 4'h6; #1;
    check("R8 input read 2", rd_data[31:28], 4'h6);

    mask_wr = 1; mask_wr_data = 16'h1234;
    @(negedge clk);
    mask_wr = 0;
    check("R10 mask write", clk_disable_mask, 16'h1234);
    @(negedge clk);
    check("R10 mask held", clk_disable_mask, 16'h1234);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule